// File: doc/BRIEF.md
# Broadside Scratchpad Register Exchange

This block is a shared scratchpad of three banks, each holding thirty 32-bit words, placed between two processor cores. Each core reaches it through a wide port that carries its entire 30-word register file as one 960-bit image. A single command can save that image into a bank, restore a bank into the core, trade the image with a bank, or trade images directly with the other core. Whichever transfer is chosen, it completes on one clock edge.

Every cycle, each core drives an opcode, a bank select and its current image. One cycle later the block returns a registered image with a one-cycle update strobe. It also returns a busy flag when the command was refused. The bank contents change on the same edge that captures the returned image. When both cores name the same bank in the same cycle, core 0 is served and core 1 is refused. A core-to-core exchange happens only when both cores request it in the same cycle.

Top module: `scratch_xchg`

## Requirements
- R1: After an active-low reset, every bank holds all zeros, both returned images are zero, and both update strobes and busy flags are low.
- R2: Opcode 001 (store) with a bank select below 3 writes the core's image into the selected bank. It does not raise that core's update strobe or busy flag.
- R3: Opcode 010 (load) with a bank select below 3 presents the selected bank's contents on that core's returned image on the next cycle, with the update strobe high.
- R4: Opcode 011 (swap) returns the selected bank's old contents to the core and writes the core's image into the bank, both on the same clock edge.
- R5: When both cores issue opcode 100 in the same cycle, on the next cycle each core's returned image equals the other core's image from the command cycle, and both strobes are high.
- R6: Opcode 100 issued by only one core raises that core's busy flag on the next cycle and changes nothing else.
- R7: When both cores issue bank opcodes (001, 010 or 011) to the same valid bank in the same cycle, core 0's command takes effect. Core 1 gets busy and no update, and core 1's command leaves the bank unchanged.
- R8: Bank commands from the two cores that target different banks both take effect in the same cycle.
- R9: A bank opcode whose bank select is 3 raises that core's busy flag on the next cycle and changes no bank and no returned image.
- R10: Opcodes 000, 101, 110 and 111 have no effect. On the next cycle the strobe and busy flag are low and the returned image keeps its previous value.
- R11: The update strobe and busy flag are registered, never high together, and stay high for exactly one cycle per command. Word k of every image occupies bits 32k+31 down to 32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| c0_cmd | input | 3 | Core 0 opcode |
| c0_bank | input | 2 | Core 0 bank select |
| c0_img | input | 960 | Core 0 current register-file image |
| c0_rd_img | output | 960 | Image returned to core 0 |
| c0_upd | output | 1 | Core 0 must take c0_rd_img |
| c0_busy | output | 1 | Core 0 command refused |
| c1_cmd | input | 3 | Core 1 opcode |
| c1_bank | input | 2 | Core 1 bank select |
| c1_img | input | 960 | Core 1 current register-file image |
| c1_rd_img | output | 960 | Image returned to core 1 |
| c1_upd | output | 1 | Core 1 must take c1_rd_img |
| c1_busy | output | 1 | Core 1 command refused |

## Verification
The bench targets same-bank collisions between the two cores. A design without core-0 priority would corrupt the bank or update core 1 as well. It drives swaps, where a design reading the bank after the write would hand back the core's own image instead of the old bank data. It also drives one-sided core exchanges, which a faulty design would perform anyway or leave unflagged. Bank select 3 and unused opcodes are aimed at designs that alias a bank or that disturb the held returned image.

// File: rtl/sx_pkg.sv
// Shared opcode type and helpers for the scratchpad exchange.
// Assumes a 3-bit opcode field driven by each core every cycle.
package sx_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_STORE = 3'd1,
        OP_LOAD  = 3'd2,
        OP_SWAP  = 3'd3,
        OP_XCHG  = 3'd4
    } sx_op_e;

    // True for the opcodes that touch a bank.
    function automatic logic is_bank_op(input logic [2:0] op);
        return (op == OP_STORE) || (op == OP_LOAD) || (op == OP_SWAP);
    endfunction

    // True for bank opcodes that write the bank.
    function automatic logic writes_bank(input logic [2:0] op);
        return (op == OP_STORE) || (op == OP_SWAP);
    endfunction

    // True for bank opcodes that return the bank to the core.
    function automatic logic reads_bank(input logic [2:0] op);
        return (op == OP_LOAD) || (op == OP_SWAP);
    endfunction
endpackage

// File: rtl/sx_arbiter.sv
// Decides which commands proceed in the current cycle.
// Core 0 wins a same-bank collision. A core exchange needs both cores.
// A bank select at or above NUM_BANKS is refused. Purely combinational.
module sx_arbiter #(
    parameter int NUM_BANKS = 3,
    parameter int SEL_W     = 2
) (
    input  logic [2:0]       cmd0,
    input  logic [SEL_W-1:0] sel0,
    input  logic [2:0]       cmd1,
    input  logic [SEL_W-1:0] sel1,
    output logic             bank_go0,
    output logic             bank_go1,
    output logic             xchg_go,
    output logic             busy0,
    output logic             busy1
);
    import sx_pkg::*;

    logic valid0, valid1;

    // Grant and refusal decisions for both cores.
    always_comb begin
        valid0   = sel0 < SEL_W'(NUM_BANKS);
        valid1   = sel1 < SEL_W'(NUM_BANKS);
        xchg_go  = (cmd0 == OP_XCHG) && (cmd1 == OP_XCHG);
        bank_go0 = is_bank_op(cmd0) && valid0;
        bank_go1 = is_bank_op(cmd1) && valid1 && !(bank_go0 && (sel0 == sel1));
        busy0    = (is_bank_op(cmd0) && !valid0) || ((cmd0 == OP_XCHG) && !xchg_go);
        busy1    = (is_bank_op(cmd1) && !bank_go1) || ((cmd1 == OP_XCHG) && !xchg_go);
    end
endmodule

// File: rtl/sx_bank_array.sv
// Holds NUM_BANKS full register-file images, with two write ports and two
// read ports. Reads return pre-edge contents, so a swap sees old data.
// Assumes the two write enables never target the same bank together.
module sx_bank_array #(
    parameter int NUM_BANKS = 3,
    parameter int IMG_W     = 960,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en0,
    input  logic [SEL_W-1:0] sel0,
    input  logic [IMG_W-1:0] wdata0,
    input  logic             wr_en1,
    input  logic [SEL_W-1:0] sel1,
    input  logic [IMG_W-1:0] wdata1,
    output logic [IMG_W-1:0] rdata0,
    output logic [IMG_W-1:0] rdata1
);
    logic [IMG_W-1:0] bank_q [NUM_BANKS];

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        logic [IMG_W-1:0] q;

        // One bank: core 0 write first, then core 1, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en0 && (sel0 == SEL_W'(gb))) begin
                q <= wdata0;
            end else if (wr_en1 && (sel1 == SEL_W'(gb))) begin
                q <= wdata1;
            end
        end

        assign bank_q[gb] = q;
    end

    // Read multiplexers; an out-of-range select reads zero.
    always_comb begin
        rdata0 = '0;
        rdata1 = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel0 == SEL_W'(b)) rdata0 = bank_q[b];
            if (sel1 == SEL_W'(b)) rdata1 = bank_q[b];
        end
    end
endmodule

// File: rtl/sx_core_port.sv
// Output stage for one core: registered returned image, strobe and busy.
// The image holds its value until the next accepted load.
module sx_core_port #(
    parameter int IMG_W = 960
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IMG_W-1:0] load_data,
    input  logic             busy_in,
    output logic [IMG_W-1:0] rd_img,
    output logic             upd,
    output logic             busy
);
    // Register the per-core results one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_img <= '0;
            upd    <= 1'b0;
            busy   <= 1'b0;
        end else begin
            upd  <= load_en;
            busy <= busy_in;
            if (load_en) rd_img <= load_data;
        end
    end
endmodule

// File: rtl/scratch_xchg.sv
// Top level: scratchpad with broadside exchange ports for two cores.
// Each core drives opcode, bank select and full image every cycle. Results
// are registered one cycle later, and bank writes land on the same edge.
module scratch_xchg #(
    parameter int NUM_BANKS = 3,
    parameter int NUM_REGS  = 30,
    parameter int REG_W     = 32,
    parameter int SEL_W     = $clog2(NUM_BANKS + 1),
    parameter int IMG_W     = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       c0_cmd,
    input  logic [SEL_W-1:0] c0_bank,
    input  logic [IMG_W-1:0] c0_img,
    output logic [IMG_W-1:0] c0_rd_img,
    output logic             c0_upd,
    output logic             c0_busy,
    input  logic [2:0]       c1_cmd,
    input  logic [SEL_W-1:0] c1_bank,
    input  logic [IMG_W-1:0] c1_img,
    output logic [IMG_W-1:0] c1_rd_img,
    output logic             c1_upd,
    output logic             c1_busy
);
    import sx_pkg::*;

    logic             bank_go0, bank_go1, xchg_go, busy0, busy1;
    logic             wr_en0, wr_en1, ld0, ld1;
    logic [IMG_W-1:0] rdata0, rdata1, ldata0, ldata1;

    sx_arbiter #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_arb (
        .cmd0(c0_cmd), .sel0(c0_bank), .cmd1(c1_cmd), .sel1(c1_bank),
        .bank_go0(bank_go0), .bank_go1(bank_go1), .xchg_go(xchg_go),
        .busy0(busy0), .busy1(busy1)
    );

    // Steer granted commands into bank writes and core loads.
    always_comb begin
        wr_en0 = bank_go0 && writes_bank(c0_cmd);
        wr_en1 = bank_go1 && writes_bank(c1_cmd);
        ld0    = (bank_go0 && reads_bank(c0_cmd)) || xchg_go;
        ld1    = (bank_go1 && reads_bank(c1_cmd)) || xchg_go;
        ldata0 = xchg_go ? c1_img : rdata0;
        ldata1 = xchg_go ? c0_img : rdata1;
    end

    sx_bank_array #(.NUM_BANKS(NUM_BANKS), .IMG_W(IMG_W), .SEL_W(SEL_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .wr_en0(wr_en0), .sel0(c0_bank), .wdata0(c0_img),
        .wr_en1(wr_en1), .sel1(c1_bank), .wdata1(c1_img),
        .rdata0(rdata0), .rdata1(rdata1)
    );

    sx_core_port #(.IMG_W(IMG_W)) u_port0 (
        .clk(clk), .rst_n(rst_n), .load_en(ld0), .load_data(ldata0),
        .busy_in(busy0), .rd_img(c0_rd_img), .upd(c0_upd), .busy(c0_busy)
    );

    sx_core_port #(.IMG_W(IMG_W)) u_port1 (
        .clk(clk), .rst_n(rst_n), .load_en(ld1), .load_data(ldata1),
        .busy_in(busy1), .rd_img(c1_rd_img), .upd(c1_upd), .busy(c1_busy)
    );
endmodule

// File: rtl/sx_xchg_chk.sv
// Property checker for scratch_xchg, attached with bind below.
// Relates the command inputs of one cycle to the port outputs of the next.
module sx_xchg_chk #(
    parameter int NUM_BANKS = 3,
    parameter int SEL_W     = 2,
    parameter int IMG_W     = 960
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       c0_cmd,
    input logic [SEL_W-1:0] c0_bank,
    input logic [IMG_W-1:0] c0_img,
    input logic [IMG_W-1:0] c0_rd_img,
    input logic             c0_upd,
    input logic             c0_busy,
    input logic [2:0]       c1_cmd,
    input logic [SEL_W-1:0] c1_bank,
    input logic [IMG_W-1:0] c1_img,
    input logic [IMG_W-1:0] c1_rd_img,
    input logic             c1_upd,
    input logic             c1_busy
);
    logic c0_bankop, c1_bankop;
    assign c0_bankop = (c0_cmd == 3'd1) || (c0_cmd == 3'd2) || (c0_cmd == 3'd3);
    assign c1_bankop = (c1_cmd == 3'd1) || (c1_cmd == 3'd2) || (c1_cmd == 3'd3);

    // R11
    upd_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(c0_upd && c0_busy) && !(c1_upd && c1_busy));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_cmd == 3'd0 || c0_cmd > 3'd4) |=>
        (!c0_upd && !c0_busy && c0_rd_img == $past(c0_rd_img)));

    // R5
    core_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_cmd == 3'd4 && c1_cmd == 3'd4) |=>
        (c0_upd && c1_upd && c0_rd_img == $past(c1_img) && c1_rd_img == $past(c0_img)));

    // R6
    lone_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_cmd == 3'd4 && c1_cmd != 3'd4) |=> (c0_busy && !c0_upd));

    // R7
    same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_bankop && c1_bankop && c0_bank == c1_bank &&
         c0_bank < SEL_W'(NUM_BANKS)) |=> (c1_busy && !c1_upd && !c0_busy));

    // R9
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_bankop && c1_bank >= SEL_W'(NUM_BANKS)) |=>
        (c1_busy && c1_rd_img == $past(c1_rd_img)));
endmodule

bind scratch_xchg sx_xchg_chk #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .IMG_W(IMG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .c0_cmd(c0_cmd), .c0_bank(c0_bank), .c0_img(c0_img),
    .c0_rd_img(c0_rd_img), .c0_upd(c0_upd), .c0_busy(c0_busy),
    .c1_cmd(c1_cmd), .c1_bank(c1_bank), .c1_img(c1_img),
    .c1_rd_img(c1_rd_img), .c1_upd(c1_upd), .c1_busy(c1_busy)
);

// File: tb/scratch_xchg_tb_top.sv
// Bench for scratch_xchg: behavioural model updated per clock and compared
// against every output one time unit after each rising edge.
module scratch_xchg_tb_top;
    localparam int W = 960;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   c0_cmd = '0, c1_cmd = '0;
    logic [1:0]   c0_bank = '0, c1_bank = '0;
    logic [W-1:0] c0_img = '0, c1_img = '0;
    logic [W-1:0] c0_rd_img, c1_rd_img;
    logic         c0_upd, c0_busy, c1_upd, c1_busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_bank [3];
    logic [W-1:0] e_rd0, e_rd1;
    logic         e_upd0, e_busy0, e_upd1, e_busy1;

    scratch_xchg dut_i (
        .clk(clk), .rst_n(rst_n),
        .c0_cmd(c0_cmd), .c0_bank(c0_bank), .c0_img(c0_img),
        .c0_rd_img(c0_rd_img), .c0_upd(c0_upd), .c0_busy(c0_busy),
        .c1_cmd(c1_cmd), .c1_bank(c1_bank), .c1_img(c1_img),
        .c1_rd_img(c1_rd_img), .c1_upd(c1_upd), .c1_busy(c1_busy)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] mk_img();
        logic [W-1:0] v;
        for (int k = 0; k < 30; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    task automatic cmp_img(string req, string nm, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
        end
    endtask

    task automatic cmp_bit(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, nm, act, exp);
        end
    endtask

    task automatic compare(string req);
        cmp_img(req, "c0_rd_img", c0_rd_img, e_rd0);
        cmp_bit(req, "c0_upd", c0_upd, e_upd0);
        cmp_bit(req, "c0_busy", c0_busy, e_busy0);
        cmp_img(req, "c1_rd_img", c1_rd_img, e_rd1);
        cmp_bit(req, "c1_upd", c1_upd, e_upd1);
        cmp_bit(req, "c1_busy", c1_busy, e_busy1);
    endtask

    // One command cycle: drive, let the edge pass, update model, compare.
    task automatic step(int k0, int b0, logic [W-1:0] i0,
                        int k1, int b1, logic [W-1:0] i1, string req);
        logic [W-1:0] old [3];
        bit both_x, c0_took;
        @(negedge clk);
        c0_cmd = 3'(k0); c0_bank = 2'(b0); c0_img = i0;
        c1_cmd = 3'(k1); c1_bank = 2'(b1); c1_img = i1;
        @(posedge clk);
        for (int b = 0; b < 3; b++) old[b] = m_bank[b];
        e_upd0 = 0; e_busy0 = 0; e_upd1 = 0; e_busy1 = 0;
        both_x  = (k0 == 4) && (k1 == 4);
        c0_took = 0;
        if (k0 >= 1 && k0 <= 3) begin
            if (b0 > 2) e_busy0 = 1;
            else begin
                c0_took = 1;
                if (k0 != 1) begin e_rd0 = old[b0]; e_upd0 = 1; end
                if (k0 != 2) m_bank[b0] = i0;
            end
        end else if (k0 == 4) begin
            if (both_x) begin e_rd0 = i1; e_upd0 = 1; end
            else e_busy0 = 1;
        end
        if (k1 >= 1 && k1 <= 3) begin
            if (b1 > 2 || (c0_took && b0 == b1)) e_busy1 = 1;
            else begin
                if (k1 != 1) begin e_rd1 = old[b1]; e_upd1 = 1; end
                if (k1 != 2) m_bank[b1] = i1;
            end
        end else if (k1 == 4) begin
            if (both_x) begin e_rd1 = i0; e_upd1 = 1; end
            else e_busy1 = 1;
        end
        #1;
        compare(req);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ia, ib, ic, id;
        for (int b = 0; b < 3; b++) m_bank[b] = '0;
        e_rd0 = '0; e_rd1 = '0;
        e_upd0 = 0; e_busy0 = 0; e_upd1 = 0; e_busy1 = 0;
        repeat (3) @(negedge clk);
        #1; compare("R1");
        rst_n = 1'b1;
        ia = mk_img(); ib = mk_img(); ic = mk_img(); id = mk_img();
        // R1: banks read back as zero after reset
        step(2, 0, '0, 2, 1, '0, "R1");
        step(2, 2, '0, 0, 0, '0, "R1");
        // R2: stores from both cores, no strobe
        step(1, 0, ia, 1, 2, ib, "R2");
        // R3: load back what was stored, crosswise
        step(2, 2, '0, 2, 0, '0, "R3");
        step(0, 0, '0, 0, 0, '0, "R11");
        // R4: swap returns old bank, bank then holds the core image
        step(3, 0, ic, 0, 0, '0, "R4");
        step(0, 0, '0, 2, 0, '0, "R4");
        // R5: core-to-core exchange
        step(4, 0, ia, 4, 0, id, "R5");
        // R6: one-sided exchange from each core
        step(4, 0, ib, 0, 0, ic, "R6");
        step(0, 0, ib, 4, 2, ic, "R6");
        // R7: both cores store to bank 1; core 0 wins
        step(1, 1, ia, 1, 1, ib, "R7");
        step(2, 1, '0, 3, 1, ic, "R7");
        step(0, 0, '0, 2, 1, '0, "R7");
        // R8: different banks in the same cycle
        step(1, 1, id, 3, 2, ia, "R8");
        step(2, 2, '0, 2, 1, '0, "R8");
        // R9: bank select 3 is refused
        step(1, 3, ic, 3, 3, id, "R9");
        step(2, 0, '0, 2, 2, '0, "R9");
        // R10: no-op and unused opcodes hold everything
        step(0, 1, ia, 5, 0, ib, "R10");
        step(6, 2, ic, 7, 1, id, "R10");
        step(2, 0, '0, 2, 1, '0, "R10");
        // R11: strobe lasts one cycle after a load
        step(0, 0, '0, 0, 0, '0, "R11");
        for (int n = 0; n < 400; n++) begin
            int k0, k1;
            k0 = $urandom_range(0, 7);
            k1 = (n % 5 == 0) ? k0 : $urandom_range(0, 7);
            step(k0, $urandom_range(0, 3), mk_img(),
                 k1, $urandom_range(0, 3), mk_img(), "R11");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule